// File: doc/BRIEF.md
# Conditional Compare Execution Unit

This unit executes one conditional-compare instruction per cycle in the execute stage of a small processor core. Each cycle it takes a 32-bit instruction word, the current condition flags, and the two operand values read from the register file. It returns the flag value that the core should commit. If the instruction's condition holds against the current flags, the new flags come from comparing the first operand with a second operand. The comparison is a subtract or an add, and the arithmetic result itself is thrown away. If the condition fails, the new flags are a literal taken from the instruction.

The second operand is either a register value or a small unsigned immediate held in the instruction. A width bit selects a compare over the full datapath or over its lower half. Encodings with reserved bits set, or with the flag-setting bit clear, are flagged as unallocated, and the flags are left unchanged. The register file, register index decoding into read ports, fetch and exception entry all sit outside the unit. The core feeds this unit the values that the Rn and Rm index fields select.

Top module: `ccmp_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `flags_out` and `undef_out` are registered there. After reset, `out_valid`, `undef_out` and `flags_out` are all 0.
- R2: An instruction with bit 29 equal to 0 sets `undef_out` and returns `flags_in` unchanged.
- R3: An instruction with bit 10 or bit 4 equal to 1 sets `undef_out` and returns `flags_in` unchanged.
- R4: Condition codes 14 and 15 (bits 15:12) always pass, whatever the flags are.
- R5: Conditions are evaluated on `flags_in`, where bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V. Codes 0/1 test Z set/clear. Codes 2/3 test C set/clear. Codes 4/5 test N set/clear. Codes 6/7 test V set/clear. Codes 8/9 test (C and not Z) true/false. Codes 10/11 test N==V true/false. Codes 12/13 test (not Z and N==V) true/false.
- R6: When the condition fails, `flags_out` equals instruction bits 3:0, in the same N,Z,C,V order.
- R7: When the condition passes and bit 30 is 1, the flags come from A minus B at the compare width. N is the top result bit. Z is set when the result is zero. C is set when A >= B, compared unsigned. V is set on signed overflow.
- R8: When the condition passes and bit 30 is 0, the flags come from A plus B at the compare width. C is the carry out and V is signed overflow.
- R9: Bits 9:5 index A and bits 20:16 index B. If bit 11 is 1, B is bits 20:16 zero-extended. If bit 11 is 0, B is `rm_val`. For either operand, a register index of 31 makes that operand zero.
- R10: When bit 31 is 1, the compare spans all XLEN bits. When bit 31 is 0, it spans the low XLEN/2 bits, and the upper operand bits have no effect.
- R11: While `in_valid` is low, `flags_out` and `undef_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| rn_val | input | XLEN | Value of register indexed by bits 9:5 |
| rm_val | input | XLEN | Value of register indexed by bits 20:16 |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| undef_out | output | 1 | Unallocated encoding seen |

## Verification
The bench builds the unit with XLEN = 8, so a half-width compare is 4 bits wide and a full-width compare is 8 bits wide. At these widths, every operand pair at half width is swept for both add and subtract, with non-zero upper bits present to show they are ignored. At full width, every first operand is swept against a spread of second operands. Every immediate is swept at both widths. All 16 condition codes are crossed with all 16 flag values, and every sign, carry and overflow boundary is reached inside the sweep.

// File: rtl/ccmp_unit.sv
module ccmp_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [3:0]      flags_in,
  input  logic [XLEN-1:0] rn_val,
  input  logic [XLEN-1:0] rm_val,
  output logic            out_valid,
  output logic [3:0]      flags_out,
  output logic            undef_out
);
  localparam int HALF  = XLEN / 2;
  localparam int IMM_W = 5;
  localparam logic [4:0] ZERO_IDX = 5'd31;

  logic       sf, op, set_bit, use_imm, rsv_a, rsv_b;
  logic [4:0] b_idx, a_idx;
  logic [3:0] cond, lit;

  assign sf      = instr[31];
  assign op      = instr[30];
  assign set_bit = instr[29];
  assign b_idx   = instr[20:16];
  assign cond    = instr[15:12];
  assign use_imm = instr[11];
  assign rsv_a   = instr[10];
  assign a_idx   = instr[9:5];
  assign rsv_b   = instr[4];
  assign lit     = instr[3:0];

  logic unused_opc;
  assign unused_opc = ^instr[28:21];

  logic illegal;
  assign illegal = ~set_bit | rsv_a | rsv_b;

  logic fn, fz, fc, fv;
  assign {fn, fz, fc, fv} = flags_in;

  logic base, cond_ok;
  always_comb begin
    case (cond[3:1])
      3'd0:    base = fz;
      3'd1:    base = fc;
      3'd2:    base = fn;
      3'd3:    base = fv;
      3'd4:    base = fc & ~fz;
      3'd5:    base = (fn == fv);
      3'd6:    base = ~fz & (fn == fv);
      default: base = 1'b1;
    endcase
  end
  assign cond_ok = (cond[3:1] == 3'b111) ? 1'b1 : (base ^ cond[0]);

  logic [XLEN-1:0] opa, opb, binv;
  assign opa  = (a_idx == ZERO_IDX) ? '0 : rn_val;
  assign opb  = use_imm ? {{(XLEN-IMM_W){1'b0}}, b_idx}
                        : ((b_idx == ZERO_IDX) ? '0 : rm_val);
  assign binv = op ? ~opb : opb;

  logic [XLEN:0] sum_w;
  logic [HALF:0] sum_h;
  assign sum_w = {1'b0, opa} + {1'b0, binv} + {{XLEN{1'b0}}, op};
  assign sum_h = {1'b0, opa[HALF-1:0]} + {1'b0, binv[HALF-1:0]} + {{HALF{1'b0}}, op};

  logic [3:0] flags_w, flags_h, cmp_flags, next_flags;
  assign flags_w = {sum_w[XLEN-1], ~|sum_w[XLEN-1:0], sum_w[XLEN],
                    (opa[XLEN-1] == binv[XLEN-1]) & (sum_w[XLEN-1] != opa[XLEN-1])};
  assign flags_h = {sum_h[HALF-1], ~|sum_h[HALF-1:0], sum_h[HALF],
                    (opa[HALF-1] == binv[HALF-1]) & (sum_h[HALF-1] != opa[HALF-1])};
  assign cmp_flags  = sf ? flags_w : flags_h;
  assign next_flags = illegal ? flags_in : (cond_ok ? cmp_flags : lit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      flags_out <= 4'h0;
      undef_out <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        flags_out <= next_flags;
        undef_out <= illegal;
      end
    end
  end

  assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_clear_s_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !instr[29] |=> undef_out && flags_out == $past(flags_in));
  assert_reserved_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (instr[10] || instr[4]) |=> undef_out && flags_out == $past(flags_in));
  assert_always_compares_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !illegal && instr[15:13] == 3'b111 |=> flags_out == $past(cmp_flags));
  assert_fail_loads_lit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !illegal && !cond_ok |=> !undef_out && flags_out == $past(instr[3:0]));
  assert_equal_sub_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !illegal && cond_ok && op && sf && opa == opb |=> flags_out[2:1] == 2'b11);
  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(flags_out) && $stable(undef_out));
endmodule

// File: tb/test_ccmp_unit.sv
`timescale 1ns/1ps
module test_ccmp_unit;
  localparam int XLEN = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [31:0]     instr = '0;
  logic [3:0]      flags_in = '0;
  logic [XLEN-1:0] rn_val = '0;
  logic [XLEN-1:0] rm_val = '0;
  logic            out_valid;
  logic [3:0]      flags_out;
  logic            undef_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ccmp_unit #(.XLEN(XLEN)) i_ccmp_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .flags_in(flags_in), .rn_val(rn_val), .rm_val(rm_val),
    .out_valid(out_valid), .flags_out(flags_out), .undef_out(undef_out));

  function automatic logic [31:0] mk(input bit sf, input bit op, input bit s,
      input logic [4:0] y, input logic [3:0] c, input bit imm, input bit o2,
      input logic [4:0] rn, input bit o3, input logic [3:0] lit);
    return {sf, op, s, 8'b11010010, y, c, imm, o2, rn, o3, lit};
  endfunction

  function automatic bit holds(input logic [3:0] c, input logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      4'd0: return z;            4'd1: return !z;
      4'd2: return cy;           4'd3: return !cy;
      4'd4: return n;            4'd5: return !n;
      4'd6: return v;            4'd7: return !v;
      4'd8: return cy && !z;     4'd9: return !(cy && !z);
      4'd10: return n == v;      4'd11: return n != v;
      4'd12: return !z && n == v; 4'd13: return !(!z && n == v);
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [4:0] model(input logic [31:0] ins, input logic [3:0] f,
      input logic [7:0] rv, input logic [7:0] mv);
    int w, m, a, b, r, sa, sb, sr;
    bit n, z, c, v;
    if (!ins[29] || ins[10] || ins[4]) return {1'b1, f};
    if (!holds(ins[15:12], f)) return {1'b0, ins[3:0]};
    w = ins[31] ? 8 : 4;
    m = 1 << w;
    a = (ins[9:5] == 5'd31) ? 0 : int'(rv);
    if (ins[11]) b = int'(ins[20:16]);
    else b = (ins[20:16] == 5'd31) ? 0 : int'(mv);
    a = a % m; b = b % m;
    sa = (a >= m/2) ? a - m : a;
    sb = (b >= m/2) ? b - m : b;
    if (ins[30]) begin r = a - b; c = (a >= b); sr = sa - sb; end
    else begin r = a + b; c = (r >= m); sr = sa + sb; end
    v = (sr < -(m/2)) || (sr >= m/2);
    r = ((r % m) + m) % m;
    n = (r >= m/2);
    z = (r == 0);
    return {1'b0, n, z, c, v};
  endfunction

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {valid,undef,nzcv} got %b expected %b (instr %h)", tag, act, exp, instr);
    end
  endtask

  task automatic issue(input logic [31:0] ins, input logic [3:0] f,
      input logic [7:0] a, input logic [7:0] b, input string tag);
    @(negedge clk);
    instr = ins; flags_in = f; rn_val = a; rm_val = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {out_valid, undef_out, flags_out}, {1'b1, model(ins, f, a, b)});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] hold_f;
    repeat (3) @(negedge clk);
    check("R1 reset", {out_valid, undef_out, flags_out}, 6'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset idle", {out_valid, undef_out, flags_out}, 6'b0);

    // R4 R5 R6: every condition code against every flag value
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        issue(mk(1, 1, 1, 5'd2, 4'(c), 1, 0, 5'd0, 0, 4'b1101), 4'(f), 8'd5, 8'd0,
              (c >= 14) ? "R4 always" : "R5/R6 cond");

    // R7 R8 R10: half width, exhaustive, garbage in upper bits
    for (int op = 0; op < 2; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          issue(mk(0, 1'(op), 1, 5'd3, 4'd14, 0, 0, 5'd1, 0, 4'h0), 4'h0,
                8'(a | ((a * 7 + 3) << 4)), 8'(b | ((b * 5 + 9) << 4)),
                op ? "R7/R10 sub half" : "R8/R10 add half");

    // R7 R8: full width
    for (int op = 0; op < 2; op++)
      for (int a = 0; a < 256; a++)
        for (int bi = 0; bi < 16; bi++)
          issue(mk(1, 1'(op), 1, 5'd4, 4'd15, 0, 0, 5'd2, 0, 4'h0), 4'h0,
                8'(a), 8'((bi * 17) ^ (bi << 3)), op ? "R7 sub full" : "R8 add full");

    // R9 R10: immediate operand, both widths
    for (int sf = 0; sf < 2; sf++)
      for (int op = 0; op < 2; op++)
        for (int im = 0; im < 32; im++)
          for (int a = 0; a < 256; a += 3)
            issue(mk(1'(sf), 1'(op), 1, 5'(im), 4'd14, 1, 0, 5'd7, 0, 4'h0), 4'h0,
                  8'(a), 8'hA5, "R9 immediate");

    // R9: index 31 reads zero
    for (int v = 1; v < 256; v += 37) begin
      issue(mk(1, 1, 1, 5'd3, 4'd14, 0, 0, 5'd31, 0, 4'h0), 4'h0, 8'(v), 8'd1, "R9 rn31");
      issue(mk(1, 1, 1, 5'd31, 4'd14, 0, 0, 5'd3, 0, 4'h0), 4'h0, 8'(v), 8'(v), "R9 rm31");
    end

    // R2 R3: unallocated encodings keep flags
    for (int f = 0; f < 16; f++) begin
      issue(mk(1, 1, 0, 5'd1, 4'd0, 0, 0, 5'd1, 0, 4'hF), 4'(f), 8'd3, 8'd3, "R2 S clear");
      issue(mk(1, 1, 1, 5'd1, 4'd14, 0, 1, 5'd1, 0, 4'hF), 4'(f), 8'd3, 8'd3, "R3 bit10");
      issue(mk(0, 0, 1, 5'd1, 4'd1, 1, 0, 5'd1, 1, 4'h0), 4'(f), 8'd3, 8'd3, "R3 bit4");
    end

    // R1 R11: idle cycles hold outputs
    issue(mk(1, 1, 1, 5'd0, 4'd14, 1, 0, 5'd0, 0, 4'h0), 4'h0, 8'd0, 8'd0, "R1 setup");
    hold_f = flags_out;
    for (int k = 0; k < 4; k++) begin
      instr = mk(1, 0, 0, 5'(k), 4'(k), 0, 1, 5'(k), 1, 4'(k)); flags_in = 4'(k + 5);
      rn_val = 8'(k * 31); rm_val = 8'(k * 13);
      @(negedge clk);
      check("R11 idle hold", {out_valid, undef_out, flags_out}, {1'b0, 1'b0, hold_f});
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule